// File: doc/BRIEF.md
# Register-Mapped 16x16 Unsigned Multiplier

This peripheral sits on an AXI4-Lite slave port. It holds two 32-bit registers. The first is an operand word that software writes. It carries two unsigned 16-bit factors. The second is a product word that software reads.

On every clock edge the block multiplies the upper factor by the lower factor and stores the 32-bit result in the product register. Any new operand value therefore shows up as a product one cycle after the operand register changes. Software can read the product with no start bit and no polling.

The write address and write data channels are independent. They may arrive in either order or together. Reads complete one at a time.

Top module: `lite_mul_periph`

## Requirements
- R1: While rst_ni is low, the operand and product registers clear to zero and both response valids drop. After release, reads at either offset return 0.
- R2: The operand register sits at byte offset 0x0. Bits 31:16 hold the first factor and bits 15:0 hold the second. Reading offset 0x0 returns the value last written.
- R3: The product register sits at byte offset 0x4. It holds the full 32-bit unsigned product of the two factors, so 0xFFFF times 0xFFFF reads as 0xFFFE0001. It updates on the clock edge after the operand register changes.
- R4: A write to offset 0x4 completes with response 2'b00 (OKAY) and leaves the product register unchanged.
- R5: On writes to offset 0x0, each byte lane n (bits 8n+7:8n) updates only when w_strb_i[n] is 1. Lanes whose strobe is 0 keep their old contents.
- R6: Write address and write data may be accepted in either order or in the same cycle. b_valid_o stays low until both are accepted. Once high, it holds until b_ready_i is seen, and b_resp_o is 2'b00.
- R7: While r_valid_o is high and r_ready_i is low, r_valid_o and r_data_o hold steady and ar_ready_o stays low.
- R8: Address bits 1:0 are ignored. Offsets 0x8 and above read as zero with response 2'b00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_o | output | 1 | Write address ready |
| aw_addr_i | input | ADDR_W | Write byte address |
| w_valid_i | input | 1 | Write data valid |
| w_ready_o | output | 1 | Write data ready |
| w_data_i | input | 2*OP_W | Write data |
| w_strb_i | input | 2*OP_W/8 | Write byte strobes |
| b_valid_o | output | 1 | Write response valid |
| b_ready_i | input | 1 | Write response ready |
| b_resp_o | output | 2 | Write response, always OKAY |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_o | output | 1 | Read address ready |
| ar_addr_i | input | ADDR_W | Read byte address |
| r_valid_o | output | 1 | Read data valid |
| r_ready_i | input | 1 | Read data ready |
| r_data_o | output | 2*OP_W | Read data |
| r_resp_o | output | 2 | Read response, always OKAY |

## Verification
The hardest state to reach from the ports is a write where one channel has been accepted and the other has not yet arrived. The bench reaches it by launching the two channels from separate threads with independent delays. It samples b_valid_o in the gap to confirm that no response leaks out early.

A held-off read response is produced by delaying r_ready_i for several cycles. During that wait a second read address is kept pending, to show that it is not taken.

Randomly packed factors, including the all-ones corner, are mixed with random channel orderings and random values in the ignored low address bits.

// File: rtl/lite_mul_pkg.sv
package lite_mul_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  typedef enum logic [1:0] {SLOT_OPND, SLOT_PROD, SLOT_NONE} slot_e;
endpackage

// File: rtl/lite_mul_decode.sv
module lite_mul_decode
  import lite_mul_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output slot_e             slot_o
);
  logic [ADDR_W-1:0] word_idx;
  assign word_idx = addr_i >> 2;  // byte offset bits dropped

  always_comb begin
    if (word_idx == ADDR_W'(0))      slot_o = SLOT_OPND;
    else if (word_idx == ADDR_W'(1)) slot_o = SLOT_PROD;
    else                             slot_o = SLOT_NONE;
  end
endmodule

// File: rtl/lite_mul_wr.sv
module lite_mul_wr #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aw_valid_i,
  output logic              aw_ready_o,
  input  logic [ADDR_W-1:0] aw_addr_i,
  input  logic              w_valid_i,
  output logic              w_ready_o,
  input  logic [DATA_W-1:0] w_data_i,
  input  logic [STRB_W-1:0] w_strb_i,
  output logic              b_valid_o,
  input  logic              b_ready_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] wa_o,
  output logic [DATA_W-1:0] wd_o,
  output logic [STRB_W-1:0] ws_o
);
  logic              aw_full_q, w_full_q, b_valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic              aw_hs, w_hs;

  assign aw_ready_o = !aw_full_q && !b_valid_q;
  assign w_ready_o  = !w_full_q && !b_valid_q;
  assign aw_hs      = aw_valid_i && aw_ready_o;
  assign w_hs       = w_valid_i && w_ready_o;

  // commit as soon as both halves are present, even in the arrival cycle
  assign we_o = (aw_full_q || aw_hs) && (w_full_q || w_hs);
  assign wa_o = aw_full_q ? addr_q : aw_addr_i;
  assign wd_o = w_full_q ? data_q : w_data_i;
  assign ws_o = w_full_q ? strb_q : w_strb_i;
  assign b_valid_o = b_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      b_valid_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
    end else begin
      if (we_o) begin
        aw_full_q <= 1'b0;
        w_full_q  <= 1'b0;
        b_valid_q <= 1'b1;
      end else begin
        if (aw_hs) aw_full_q <= 1'b1;
        if (w_hs)  w_full_q  <= 1'b1;
        if (b_valid_q && b_ready_i) b_valid_q <= 1'b0;
      end
      if (aw_hs) addr_q <= aw_addr_i;
      if (w_hs) begin
        data_q <= w_data_i;
        strb_q <= w_strb_i;
      end
    end
  end

  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_valid_q && !b_ready_i |=> b_valid_q); // R6
  AST_B_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(b_valid_q) |-> $past(aw_valid_i || aw_full_q) && $past(w_valid_i || w_full_q)); // R6
endmodule

// File: rtl/lite_mul_rd.sv
module lite_mul_rd #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ADDR_W-1:0] ar_addr_i,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic [DATA_W-1:0] r_data_o,
  output logic [ADDR_W-1:0] ra_o,
  input  logic [DATA_W-1:0] rd_i
);
  logic              r_valid_q;
  logic [DATA_W-1:0] r_data_q;

  assign ar_ready_o = !r_valid_q;
  assign ra_o       = ar_addr_i;
  assign r_valid_o  = r_valid_q;
  assign r_data_o   = r_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_valid_q <= 1'b0;
      r_data_q  <= '0;
    end else if (ar_valid_i && ar_ready_o) begin
      r_valid_q <= 1'b1;
      r_data_q  <= rd_i;
    end else if (r_valid_q && r_ready_i) begin
      r_valid_q <= 1'b0;
    end
  end

  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_q && !r_ready_i |=> r_valid_q && $stable(r_data_q)); // R7
  AST_R_FROM_AR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(r_valid_q) |-> $past(ar_valid_i)); // R7
endmodule

// File: rtl/lite_mul_core.sv
module lite_mul_core
  import lite_mul_pkg::*;
#(
  parameter int OP_W = 16,
  localparam int DATA_W = 2 * OP_W,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  slot_e             wslot_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [STRB_W-1:0] ws_i,
  input  slot_e             rslot_i,
  output logic [DATA_W-1:0] rd_o
);
  logic [7:0]        lane_q [STRB_W];
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] op_hi, op_lo, prod_q;
  logic              opnd_we;

  assign opnd_we = we_i && (wslot_i == SLOT_OPND);

  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 lane_q[g] <= '0;
      else if (opnd_we && ws_i[g]) lane_q[g] <= wd_i[g*8 +: 8];
    end
    assign opnd[g*8 +: 8] = lane_q[g];
  end

  assign op_hi = {{OP_W{1'b0}}, opnd[DATA_W-1:OP_W]};
  assign op_lo = {{OP_W{1'b0}}, opnd[OP_W-1:0]};

  // full-width product: 2*OP_W bits never overflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else         prod_q <= op_hi * op_lo;
  end

  always_comb begin
    case (rslot_i)
      SLOT_OPND: rd_o = opnd;
      SLOT_PROD: rd_o = prod_q;
      default:   rd_o = '0;
    endcase
  end

  AST_PROD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(opnd) |=> $stable(prod_q)); // R3
  AST_FULL_STRB_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_we && (ws_i == '1) |=> opnd == $past(wd_i)); // R5
  AST_NO_WRITE_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !opnd_we |=> $stable(opnd)); // R4
endmodule

// File: rtl/lite_mul_periph.sv
module lite_mul_periph
  import lite_mul_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int OP_W   = 16,
  localparam int DATA_W = 2 * OP_W,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aw_valid_i,
  output logic              aw_ready_o,
  input  logic [ADDR_W-1:0] aw_addr_i,
  input  logic              w_valid_i,
  output logic              w_ready_o,
  input  logic [DATA_W-1:0] w_data_i,
  input  logic [STRB_W-1:0] w_strb_i,
  output logic              b_valid_o,
  input  logic              b_ready_i,
  output logic [1:0]        b_resp_o,
  input  logic              ar_valid_i,
  output logic              ar_ready_o,
  input  logic [ADDR_W-1:0] ar_addr_i,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic [DATA_W-1:0] r_data_o,
  output logic [1:0]        r_resp_o
);
  logic              we;
  logic [ADDR_W-1:0] wa, ra;
  logic [DATA_W-1:0] wd, rd;
  logic [STRB_W-1:0] ws;
  slot_e             wslot, rslot;

  lite_mul_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i, .rst_ni,
    .aw_valid_i, .aw_ready_o, .aw_addr_i,
    .w_valid_i, .w_ready_o, .w_data_i, .w_strb_i,
    .b_valid_o, .b_ready_i,
    .we_o(we), .wa_o(wa), .wd_o(wd), .ws_o(ws)
  );

  lite_mul_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni,
    .ar_valid_i, .ar_ready_o, .ar_addr_i,
    .r_valid_o, .r_ready_i, .r_data_o,
    .ra_o(ra), .rd_i(rd)
  );

  lite_mul_decode #(.ADDR_W(ADDR_W)) u_wdec (.addr_i(wa), .slot_o(wslot));
  lite_mul_decode #(.ADDR_W(ADDR_W)) u_rdec (.addr_i(ra), .slot_o(rslot));

  lite_mul_core #(.OP_W(OP_W)) u_core (
    .clk_i, .rst_ni,
    .we_i(we), .wslot_i(wslot), .wd_i(wd), .ws_i(ws),
    .rslot_i(rslot), .rd_o(rd)
  );

  assign b_resp_o = RESP_OKAY;
  assign r_resp_o = RESP_OKAY;

  AST_AR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_o && !r_ready_i |=> !ar_ready_o); // R7
endmodule

// File: tb/sim_lite_mul_periph.sv
module sim_lite_mul_periph;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        aw_valid = 1'b0, w_valid = 1'b0, b_ready = 1'b0;
  logic        ar_valid = 1'b0, r_ready = 1'b0;
  logic [3:0]  aw_addr = '0, ar_addr = '0;
  logic [31:0] w_data = '0;
  logic [3:0]  w_strb = '0;
  logic        aw_ready, w_ready, b_valid, ar_ready, r_valid;
  logic [1:0]  b_resp, r_resp;
  logic [31:0] r_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lite_mul_periph u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .aw_valid_i(aw_valid), .aw_ready_o(aw_ready), .aw_addr_i(aw_addr),
    .w_valid_i(w_valid), .w_ready_o(w_ready), .w_data_i(w_data), .w_strb_i(w_strb),
    .b_valid_o(b_valid), .b_ready_i(b_ready), .b_resp_o(b_resp),
    .ar_valid_i(ar_valid), .ar_ready_o(ar_ready), .ar_addr_i(ar_addr),
    .r_valid_o(r_valid), .r_ready_i(r_ready), .r_data_o(r_data), .r_resp_o(r_resp)
  );

  function automatic logic [31:0] prod_of(input logic [31:0] op);
    return {16'h0, op[31:16]} * {16'h0, op[15:0]};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, nw, input logic [3:0] s);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = s[i] ? nw[i*8 +: 8] : old[i*8 +: 8];
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                    input int daw, input int dw, input int db);
    @(negedge clk);
    fork
      begin
        repeat (daw) @(negedge clk);
        if (daw > dw + 1) chk("R6 early b", {31'h0, b_valid}, 32'h0);
        aw_valid = 1'b1; aw_addr = a;
        while (!aw_ready) @(negedge clk);
        @(negedge clk); aw_valid = 1'b0;
      end
      begin
        repeat (dw) @(negedge clk);
        if (dw > daw + 1) chk("R6 early b", {31'h0, b_valid}, 32'h0);
        w_valid = 1'b1; w_data = d; w_strb = s;
        while (!w_ready) @(negedge clk);
        @(negedge clk); w_valid = 1'b0;
      end
    join
    while (!b_valid) @(negedge clk);
    chk("R6 bresp", {30'h0, b_resp}, 32'h0);
    for (int i = 0; i < db; i++) begin
      @(negedge clk);
      chk("R6 b hold", {31'h0, b_valid}, 32'h1);
    end
    b_ready = 1'b1;
    @(negedge clk); b_ready = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input int dr, output logic [31:0] d);
    @(negedge clk);
    ar_valid = 1'b1; ar_addr = a;
    while (!ar_ready) @(negedge clk);
    @(negedge clk);
    ar_valid = (dr > 0);  // keep a second request waiting during hold-off
    while (!r_valid) @(negedge clk);
    d = r_data;
    chk("R8 rresp", {30'h0, r_resp}, 32'h0);
    for (int i = 0; i < dr; i++) begin
      @(negedge clk);
      chk("R7 r hold", {30'h0, r_valid, ar_ready}, 32'h2);
      chk("R7 data stable", r_data, d);
    end
    ar_valid = 1'b0;
    r_ready = 1'b1;
    @(negedge clk); r_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, opnd, nw;
    logic [3:0] s;
    void'($urandom(32'd715));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    // R1 reset state
    chk("R1 valids", {30'h0, b_valid, r_valid}, 32'h0);
    rd(4'h0, 0, v); chk("R1 opnd", v, 32'h0);
    rd(4'h4, 0, v); chk("R1 prod", v, 32'h0);

    // R2 / R3 all-ones corner
    opnd = 32'hFFFF_FFFF;
    wr(4'h0, opnd, 4'hF, 0, 0, 0);
    rd(4'h4, 0, v); chk("R3 max", v, 32'hFFFE_0001);
    rd(4'h0, 0, v); chk("R2 readback", v, opnd);
    opnd = {16'd3, 16'd7};
    wr(4'h0, opnd, 4'hF, 0, 0, 0);
    rd(4'h4, 0, v); chk("R3 small", v, 32'd21);

    // R4 write to product slot ignored
    wr(4'h4, 32'h1234_5678, 4'hF, 0, 0, 0);
    rd(4'h4, 0, v); chk("R4 prod kept", v, 32'd21);
    rd(4'h0, 0, v); chk("R4 opnd kept", v, opnd);

    // R5 strobes
    nw = 32'hAABB_CCDD;
    wr(4'h0, nw, 4'b0101, 0, 0, 0);
    opnd = merge(opnd, nw, 4'b0101);
    rd(4'h0, 0, v); chk("R5 merge", v, opnd);
    rd(4'h4, 0, v); chk("R5 prod", v, prod_of(opnd));
    wr(4'h0, 32'h0102_0304, 4'b0000, 0, 0, 0);
    rd(4'h0, 0, v); chk("R5 no strobe", v, opnd);

    // R6 channel orderings and held response
    opnd = {16'd1000, 16'd65};
    wr(4'h0, opnd, 4'hF, 0, 4, 2);
    rd(4'h4, 0, v); chk("R6 aw first", v, prod_of(opnd));
    opnd = {16'd77, 16'd4099};
    wr(4'h0, opnd, 4'hF, 4, 0, 1);
    rd(4'h4, 0, v); chk("R6 w first", v, prod_of(opnd));

    // R7 held read response
    rd(4'h4, 3, v); chk("R7 held data", v, prod_of(opnd));

    // R8 low address bits and unmapped slots
    rd(4'h6, 0, v); chk("R8 low bits prod", v, prod_of(opnd));
    rd(4'h3, 0, v); chk("R8 low bits opnd", v, opnd);
    rd(4'h8, 0, v); chk("R8 unmapped 8", v, 32'h0);
    rd(4'hC, 0, v); chk("R8 unmapped C", v, 32'h0);
    wr(4'hA, 32'hDEAD_BEEF, 4'hF, 0, 0, 0);
    rd(4'h0, 0, v); chk("R8 unmapped write", v, opnd);
    rd(4'h4, 0, v); chk("R8 prod after unmapped", v, prod_of(opnd));

    // random mix
    for (int n = 0; n < 40; n++) begin
      nw = $urandom;
      s  = (n % 4 == 0) ? 4'($urandom) : 4'hF;
      wr({2'b00, 2'($urandom)}, nw, s, int'($urandom % 3), int'($urandom % 3), int'($urandom % 2));
      opnd = merge(opnd, nw, s);
      rd({2'b01, 2'($urandom)}, int'($urandom % 2), v);
      chk("R3 random prod", v, prod_of(opnd));
      rd({2'b00, 2'($urandom)}, 0, v);
      chk("R2 random opnd", v, opnd);
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule